// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. It carries out one register access per command: a read or a write to either the debug-port or the access-port register bank. It drives a serial clock, and it shares one bidirectional data line with the target through a data output and a separate output enable. A command is a single valid/ready beat. The block then sends the packet header, hands the line to the target, collects the 3-bit acknowledge and moves the 32-bit data word with its parity bit. A response is a valid/ready beat that carries the acknowledge, the read data and a parity-error flag.

Each serial bit takes two system clocks. The serial clock is low in the first and high in the second. The host changes its data while the serial clock is low. It samples the target at the system clock edge that ends the high half. The turnaround length and the number of low idle cycles that follow each transaction are plain configuration inputs. Both are captured when a command is accepted.

Back-pressure rules: `cmd_ready` is high only when the engine is idle and holds no response. It falls in the cycle after a command is accepted and stays low until the response has been taken. `rsp_valid` stays high, with its payload unchanged, until `rsp_ready` is seen high at a clock edge.

Top module: `swd_host_engine`

## Requirements
- R1: The header is eight host-driven bits, sent first to last as: 1, bank select, read flag, address bit 2, address bit 3, parity, 0, 1. The parity bit is the XOR of the bank select, the read flag and the two address bits.
- R2: The bank select bit is 1 for an access-port access and 0 for a debug-port access. The read flag is 1 for a read and 0 for a write. The address bits come from `cmd_addr` (byte-address bits [3:2]), with bit 2 sent first.
- R3: Every turnaround lasts `cfg_trn`+1 serial bits, and `swdio_oe` is low during it. One turnaround follows the header. A read ends with another turnaround after its parity bit.
- R4: After the first turnaround comes the acknowledge: three bits with `swdio_oe` low. The first bit received goes to `rsp_ack[0]`. OK is 3'b001.
- R5: On an OK read, the host samples 32 data bits, least significant first, and then one parity bit, with `swdio_oe` low. The data is returned on `rsp_rdata`.
- R6: On an OK write, one turnaround follows the acknowledge. The host then drives `cmd_wdata` as 32 bits, least significant first, followed by the XOR of those 32 bits.
- R7: An acknowledge other than 3'b001 skips the data phase. Only one turnaround follows. The acknowledge is reported, and `rsp_rdata` is zero. `rsp_rdata` is also zero for every write.
- R8: `rsp_perr` is high only on an OK read whose received parity bit differs from the XOR of the 32 received data bits.
- R9: After the data phase, or after the final turnaround, the host drives the line low for `cfg_idle` serial bits. Only then is the response presented.
- R10: `cmd_ready` is low from the cycle after an accept until the response is taken. `rsp_valid` and its payload hold until `rsp_ready`.
- R11: `swclk` is low for one clock and then high for one clock in each serial bit. It is high for at most one clock at a time, and it is low while the engine is idle or holds a response. After reset, `swdio_oe` is high and `swdio_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trn | input | 2 | Turnaround length minus one, in serial bits |
| cfg_idle | input | 8 | Low idle bits appended after each transaction |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine accepts a command |
| cmd_ap | input | 1 | 1 = access-port bank, 0 = debug-port bank |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register byte-address bits [3:2] |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_ack | output | 3 | Received acknowledge, first bit in bit 0 |
| rsp_rdata | output | 32 | Read data |
| rsp_perr | output | 1 | Read data parity mismatch |
| swclk | output | 1 | Serial clock |
| swdio_in | input | 1 | Data line as seen from the pad |
| swdio_out | output | 1 | Data value driven by the host |
| swdio_oe | output | 1 | Host drives the data line when high |

## Verification
The bound checker watches every cycle for four things. It checks the handshake rules: ready falls after an accept, ready stays low while a response is held, and the response stays stable under back-pressure. It checks that the serial clock is never high for two clocks in a row and is quiet between transactions. It checks that the start bit is driven right after an accept, and that a parity error only ever comes with an OK acknowledge. Only the bench scenarios can show that the bit stream on the line is right. That covers the header contents and its parity, the turnaround lengths for each setting, the split between the read, write and rejected-acknowledge sequences, the write parity and the idle-bit count. The bench plays the target bit by bit and checks each host-driven bit and each released bit against its expected stream.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  localparam int WORD_W = 32;
  localparam logic [2:0] ACK_OK = 3'b001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_TRN_A,
    ST_ACK,
    ST_RDATA,
    ST_TRN_B,
    ST_WTRN,
    ST_WDATA,
    ST_LOW,
    ST_RESP
  } swd_state_e;

  // Header bits in wire order, bit 0 leaves first.
  function automatic logic [7:0] make_header(input logic ap, input logic rd,
                                             input logic [1:0] a);
    logic p;
    p = ap ^ rd ^ a[0] ^ a[1];
    return {1'b1, 1'b0, p, a[1], a[0], rd, ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic bit_end
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= run ? ~phase : 1'b0;
  end

  assign swclk   = phase;
  assign bit_end = run & phase;
endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take_ack,
  input  logic          take_data,
  input  logic [CW-1:0] idx,
  input  logic          din,
  output logic [2:0]    ack_q,
  output logic [DW-1:0] rdata_q
);
  localparam int IW = $clog2(DW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= '0;
      rdata_q <= '0;
    end else if (clear) begin
      ack_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (take_ack)  ack_q[idx[1:0]]     <= din;
      if (take_data) rdata_q[idx[IW-1:0]] <= din;
    end
  end
endmodule

// File: rtl/swd_frame_ctrl.sv
module swd_frame_ctrl
  import swd_host_pkg::*;
#(
  parameter int TRN_W  = 2,
  parameter int IDLE_W = 8,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRN_W-1:0]  cfg_trn,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_ap,
  input  logic              cmd_read,
  input  logic [1:0]        cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_perr,
  input  logic              bit_end,
  input  logic              din,
  input  logic [2:0]        ack_q,
  input  logic [WORD_W-1:0] rdata_q,
  output logic              run,
  output logic              cap_clear,
  output logic              take_ack,
  output logic              take_data,
  output logic [CW-1:0]     cnt,
  output logic              dout,
  output logic              doe
);
  localparam logic [CW-1:0] LAST_HDR  = CW'(7);
  localparam logic [CW-1:0] LAST_ACK  = CW'(2);
  localparam logic [CW-1:0] LAST_WORD = CW'(WORD_W);
  localparam int IW = $clog2(WORD_W);

  swd_state_e        st;
  logic [TRN_W-1:0]  trn_q;
  logic [IDLE_W-1:0] idle_q;
  logic [7:0]        hdr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              rd_q;
  logic              perr_q;
  logic              accept;
  logic              trn_last;
  logic [2:0]        ack_now;
  swd_state_e        after_data;

  assign accept     = (st == ST_IDLE) && cmd_valid;
  assign cmd_ready  = (st == ST_IDLE);
  assign rsp_valid  = (st == ST_RESP);
  assign rsp_perr   = perr_q;
  assign run        = (st != ST_IDLE) && (st != ST_RESP);
  assign cap_clear  = accept;
  assign take_ack   = bit_end && (st == ST_ACK);
  assign take_data  = bit_end && (st == ST_RDATA) && (cnt != LAST_WORD);
  assign trn_last   = (cnt == CW'(trn_q));
  assign ack_now    = {din, ack_q[1:0]};
  assign after_data = (idle_q != '0) ? ST_LOW : ST_RESP;

  always_comb begin
    doe  = 1'b1;
    dout = 1'b0;
    case (st)
      ST_HDR:   dout = hdr_q[cnt[2:0]];
      ST_WDATA: dout = (cnt == LAST_WORD) ? ^wdata_q : wdata_q[cnt[IW-1:0]];
      ST_TRN_A, ST_ACK, ST_RDATA, ST_TRN_B, ST_WTRN: doe = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      trn_q   <= '0;
      idle_q  <= '0;
      hdr_q   <= '0;
      wdata_q <= '0;
      rd_q    <= 1'b0;
      perr_q  <= 1'b0;
    end else if (accept) begin
      st      <= ST_HDR;
      cnt     <= '0;
      trn_q   <= cfg_trn;
      idle_q  <= cfg_idle;
      hdr_q   <= make_header(cmd_ap, cmd_read, cmd_addr);
      wdata_q <= cmd_wdata;
      rd_q    <= cmd_read;
      perr_q  <= 1'b0;
    end else if (st == ST_RESP) begin
      if (rsp_ready) st <= ST_IDLE;
    end else if (bit_end) begin
      cnt <= cnt + 1'b1;
      case (st)
        ST_HDR:   if (cnt == LAST_HDR) begin st <= ST_TRN_A; cnt <= '0; end
        ST_TRN_A: if (trn_last) begin st <= ST_ACK; cnt <= '0; end
        ST_ACK: if (cnt == LAST_ACK) begin
          cnt <= '0;
          if (ack_now != ACK_OK) st <= ST_TRN_B;
          else                   st <= rd_q ? ST_RDATA : ST_WTRN;
        end
        ST_RDATA: if (cnt == LAST_WORD) begin
          st     <= ST_TRN_B;
          cnt    <= '0;
          perr_q <= (^rdata_q) ^ din;
        end
        ST_TRN_B:  if (trn_last) begin st <= after_data; cnt <= '0; end
        ST_WTRN:   if (trn_last) begin st <= ST_WDATA; cnt <= '0; end
        ST_WDATA:  if (cnt == LAST_WORD) begin st <= after_data; cnt <= '0; end
        ST_LOW:    if (cnt == CW'(idle_q) - 1'b1) begin st <= ST_RESP; cnt <= '0; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_host_pkg::*;
#(
  parameter int TRN_W  = 2,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRN_W-1:0]  cfg_trn,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_ap,
  input  logic              cmd_read,
  input  logic [1:0]        cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_perr,
  output logic              swclk,
  input  logic              swdio_in,
  output logic              swdio_out,
  output logic              swdio_oe
);
  localparam int CW_MIN = $clog2(WORD_W) + 1;
  localparam int CW = (IDLE_W > CW_MIN) ? IDLE_W : CW_MIN;

  logic          run, bit_end, cap_clear, take_ack, take_data;
  logic [CW-1:0] cnt;

  swd_bit_timer u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .swclk(swclk), .bit_end(bit_end)
  );

  swd_rx_capture #(.DW(WORD_W), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(cap_clear), .take_ack(take_ack),
    .take_data(take_data), .idx(cnt), .din(swdio_in),
    .ack_q(rsp_ack), .rdata_q(rsp_rdata)
  );

  swd_frame_ctrl #(.TRN_W(TRN_W), .IDLE_W(IDLE_W), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_trn(cfg_trn), .cfg_idle(cfg_idle),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ap(cmd_ap),
    .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_perr(rsp_perr),
    .bit_end(bit_end), .din(swdio_in), .ack_q(rsp_ack), .rdata_q(rsp_rdata),
    .run(run), .cap_clear(cap_clear), .take_ack(take_ack),
    .take_data(take_data), .cnt(cnt), .dout(swdio_out), .doe(swdio_oe)
  );
endmodule

// File: rtl/swd_host_checker.sv
module swd_host_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [2:0]  rsp_ack,
  input logic [31:0] rsp_rdata,
  input logic        rsp_perr,
  input logic        swclk,
  input logic        swdio_out,
  input logic        swdio_oe
);
  assert_hold_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  assert_accept_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_rsp_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ack) &&
                                   $stable(rsp_rdata) && $stable(rsp_perr)));

  assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (swdio_oe && swdio_out && !swclk));

  assert_clk_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready || rsp_valid) |-> !swclk);

  assert_clk_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    swclk |=> !swclk);

  assert_perr_ok_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perr) |-> (rsp_ack == 3'b001));
endmodule

bind swd_host_engine swd_host_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack),
  .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .swclk(swclk),
  .swdio_out(swdio_out), .swdio_oe(swdio_oe)
);

// File: tb/tb_swd_host_engine.sv
`timescale 1ns/1ps
module tb_swd_host_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_trn = '0;
  logic [7:0]  cfg_idle = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_ap = 1'b0;
  logic        cmd_read = 1'b0;
  logic [1:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        rsp_perr;
  logic        swclk;
  logic        swdio_in = 1'b1;
  logic        swdio_out;
  logic        swdio_oe;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_rise = 0;
  bit first_bit = 1'b0;
  bit prev_clk = 1'b0;

  // scoreboard: per serial bit {oe, value, target drive} with tag; per response
  logic [2:0]  q_bit[$];
  string       q_tag[$];
  logic [2:0]  q_ack[$];
  logic [31:0] q_rd[$];
  logic        q_pe[$];

  always #4 clk = ~clk;

  swd_host_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_trn(cfg_trn), .cfg_idle(cfg_idle),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ap(cmd_ap),
    .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .swclk(swclk),
    .swdio_in(swdio_in), .swdio_out(swdio_out), .swdio_oe(swdio_oe)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic oe, logic val, logic tgt, string tag);
    q_bit.push_back({oe, val, tgt});
    q_tag.push_back(tag);
  endtask

  task automatic do_txn(logic ap, logic rd, logic [1:0] a, logic [31:0] wd,
                        logic [1:0] trn, logic [7:0] idle, logic [2:0] ack,
                        logic [31:0] rdat, logic bad_par);
    logic ok;
    ok = (ack == 3'b001);
    while (!cmd_ready) @(negedge clk);
    push(1, 1, 1, "R1");
    push(1, ap, 1, "R2");
    push(1, rd, 1, "R2");
    push(1, a[0], 1, "R2");
    push(1, a[1], 1, "R2");
    push(1, ap ^ rd ^ a[0] ^ a[1], 1, "R1");
    push(1, 0, 1, "R1");
    push(1, 1, 1, "R1");
    for (int i = 0; i <= trn; i++) push(0, 0, 1, "R3");
    for (int i = 0; i < 3; i++) push(0, 0, ack[i], "R4");
    if (ok && rd) begin
      for (int i = 0; i < 32; i++) push(0, 0, rdat[i], "R5");
      push(0, 0, (^rdat) ^ bad_par, "R5");
      for (int i = 0; i <= trn; i++) push(0, 0, 1, "R3");
    end else if (ok) begin
      for (int i = 0; i <= trn; i++) push(0, 0, 1, "R6");
      for (int i = 0; i < 32; i++) push(1, wd[i], 1, "R6");
      push(1, ^wd, 1, "R6");
    end else begin
      for (int i = 0; i <= trn; i++) push(0, 0, 1, "R7");
    end
    for (int i = 0; i < idle; i++) push(1, 0, 1, "R9");
    q_ack.push_back(ack);
    q_rd.push_back((ok && rd) ? rdat : 32'h0);
    q_pe.push_back(ok && rd && bad_par);
    first_bit = 1'b1;
    cmd_ap = ap; cmd_read = rd; cmd_addr = a; cmd_wdata = wd;
    cfg_trn = trn; cfg_idle = idle;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_ap = ~ap; cmd_addr = ~a; cmd_wdata = ~wd; cfg_trn = ~trn; cfg_idle = 8'd9;
    chk("R10", "ready after accept", cmd_ready, 0);
  endtask

  // bit monitor: target side of the line
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cyc++;
        if (swclk && prev_clk) chk("R11", "clock high twice", 1, 0);
        if (swclk && !prev_clk) begin
          if (!first_bit) chk("R11", "bit period", cyc - last_rise, 2);
          first_bit = 1'b0;
          last_rise = cyc;
          if (q_bit.size() == 0) begin
            chk("R9", "unexpected serial bit", 1, 0);
          end else begin
            logic [2:0] it;
            string tg;
            it = q_bit.pop_front();
            tg = q_tag.pop_front();
            chk(tg, "oe", swdio_oe, it[2]);
            if (it[2]) chk(tg, "out", swdio_out, it[1]);
            swdio_in = it[0];
          end
        end
        prev_clk = swclk;
      end
    end
  end

  // response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        logic [2:0] ea;
        logic [31:0] ed;
        logic ep;
        ea = q_ack.pop_front();
        ed = q_rd.pop_front();
        ep = q_pe.pop_front();
        chk("R9", "bits left at response", q_bit.size(), 0);
        chk("R4", "ack", rsp_ack, ea);
        chk("R5", "rdata", rsp_rdata, ed);
        chk("R8", "perr", rsp_perr, ep);
        repeat (2) begin
          @(negedge clk);
          chk("R10", "held valid", rsp_valid, 1);
          chk("R10", "ready low", cmd_ready, 0);
          chk("R10", "held ack", rsp_ack, ea);
          chk("R11", "clock quiet", swclk, 0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R10", "released", rsp_valid, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset ready", cmd_ready, 1);
    chk("R10", "reset rsp_valid", rsp_valid, 0);
    chk("R11", "reset swclk", swclk, 0);
    chk("R11", "reset oe", swdio_oe, 1);
    chk("R11", "reset out", swdio_out, 0);
    // DP write, OK, shortest turnaround, no idle
    do_txn(0, 0, 2'b01, 32'hAAAA5555, 2'd0, 8'd0, 3'b001, 32'h0, 0);
    // AP read, OK, good parity, idle bits
    do_txn(1, 1, 2'b11, 32'h0, 2'd1, 8'd3, 3'b001, 32'h12345678, 0);
    // read with corrupted parity
    do_txn(0, 1, 2'b10, 32'h0, 2'd2, 8'd0, 3'b001, 32'hF00D_0001, 1);
    // write rejected with WAIT
    do_txn(1, 0, 2'b00, 32'hDEADBEEF, 2'd0, 8'd2, 3'b010, 32'h0, 0);
    // read rejected with FAULT, longest turnaround
    do_txn(0, 1, 2'b11, 32'h0, 2'd3, 8'd1, 3'b100, 32'hFFFFFFFF, 0);
    // write all ones, long turnaround, idle
    do_txn(1, 0, 2'b10, 32'hFFFFFFFF, 2'd3, 8'd5, 3'b001, 32'h0, 0);
    // write with odd parity data
    do_txn(0, 0, 2'b00, 32'h00000001, 2'd1, 8'd0, 3'b001, 32'h0, 0);
    // read of zero data, AP bank
    do_txn(1, 1, 2'b01, 32'h0, 2'd0, 8'd2, 3'b001, 32'h0, 0);
    while (!(cmd_ready && q_ack.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule